// File: doc/BRIEF.md
# PWM Event Interrupt and ADC Trigger Router

This block sits next to a single PWM generator and converts its timing events and the state of four protection/status inputs into one CPU interrupt request and two ADC trigger pulses. Software programs the routing through one 16-bit control word, written via a simple write strobe and data bus. The control word holds four status-interrupt enables, a two-bit time-base interrupt selector, three enables that gate compare events onto ADC trigger 2, and a five-bit skip count for ADC trigger 1.

The four status inputs are levels: fault, current-limit, feed-forward and sync. Each of them raises the interrupt only on a low-to-high transition, and only when its enable is set. The time-base interrupt comes from end-of-cycle, compare A, or the ADC trigger 1 event, as chosen by the selector, or it is switched off. ADC trigger 1 follows compare A matches with a programmable number of matches skipped between triggers. ADC trigger 2 is the gated OR of the compare A, B and C matches. All three outputs are registered single-clock pulses.

Top module: `pwm_evt_router`

## Requirements
- R1: After reset every control field is zero: status interrupts and trigger 2 are disabled, the selector is at end-of-cycle (00) and the skip count is 0. All three outputs are low while reset is held.
- R2: The status enables sit at control bits 15 (fault), 14 (current-limit), 13 (feed-forward) and 12 (sync). A status rise whose enable is clear gives no interrupt.
- R3: An enabled status input raises the interrupt only in the cycle it goes from low to high. Staying high or falling gives nothing.
- R4: Status edge history clears on reset, so an input that is already high gives no interrupt until it has been seen low and rises again.
- R5: Control bits 9:8 pick the time-base interrupt source: 00 end-of-cycle pulse, 01 compare A pulse, 10 the ADC trigger 1 event.
- R6: Selector value 11 blocks every time-base source, while the status interrupts still follow their own enables.
- R7: ADC trigger 2 pulses when compare C is seen with bit 7 set, compare B with bit 6 set, or compare A with bit 5 set. Coincident events produce one pulse.
- R8: With skip count N in control bits 4:0, ADC trigger 1 ignores N compare A pulses, fires on the next one, then reloads N. N = 0 fires on every compare A pulse.
- R9: Every control write reloads the skip counter from the newly written bits 4:0, dropping any partial count. A compare A pulse in the cycle of the write is not counted and does not fire.
- R10: Each output is registered. It is high for exactly the clock after the cycle whose inputs call for it. Several interrupt sources in one cycle give a single high cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| ctl_wr | input | 1 | Control word write strobe |
| ctl_wdata | input | 16 | Control word write data |
| eoc_pulse | input | 1 | PWM end-of-cycle event |
| cmpa_pulse | input | 1 | Compare A match event |
| cmpb_pulse | input | 1 | Compare B match event |
| cmpc_pulse | input | 1 | Compare C match event |
| flt_lvl | input | 1 | Fault status level |
| clim_lvl | input | 1 | Current-limit status level |
| ffwd_lvl | input | 1 | Feed-forward status level |
| sync_lvl | input | 1 | Sync status level |
| irq_o | output | 1 | Interrupt request pulse |
| adc1_trig_o | output | 1 | ADC trigger 1 pulse |
| adc2_trig_o | output | 1 | ADC trigger 2 pulse |

## Verification
Every result is due one clock after its cause. An event or status rise sampled at an edge shows on the outputs right after that edge. A control write takes effect for events in the following cycle, so an event that comes with the write is still routed by the old word. The bench drives inputs on the falling edge and compares outputs at the next falling edge, which puts exactly one rising edge between stimulus and check. In the skip-count runs, every compare A pulse is checked, so a trigger that comes one pulse early or late fails at that pulse.

// File: rtl/pwm_evt_pkg.sv
package pwm_evt_pkg;

    localparam int CTL_W  = 16;
    localparam int STAT_N = 4;
    localparam int CMP_N  = 3;
    localparam int OFS_W  = 5;

    typedef enum logic [1:0] {
        TB_EOC  = 2'b00,
        TB_CMPA = 2'b01,
        TB_ADC1 = 2'b10,
        TB_OFF  = 2'b11
    } tb_sel_e;

    // bit 15..12 status enables {fault, climit, ffwd, sync}
    // bit 11..10 spare, 9..8 selector, 7..5 trigger-2 gates {C,B,A}, 4..0 skip
    typedef struct packed {
        logic [STAT_N-1:0] st_en;
        logic [1:0]        spare;
        tb_sel_e           tb_sel;
        logic [CMP_N-1:0]  a2_en;
        logic [OFS_W-1:0]  ofs;
    } evt_ctl_t;

endpackage

// File: rtl/evt_ctl_reg.sv
module evt_ctl_reg
    import pwm_evt_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_i,
    input  logic [CTL_W-1:0] wdata_i,
    output evt_ctl_t         ctl_o
);
    evt_ctl_t ctl_d, ctl_q;

    always_comb begin
        ctl_d = ctl_q;
        if (wr_i) ctl_d = evt_ctl_t'(wdata_i);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctl_q <= '0;
        else        ctl_q <= ctl_d;
    end

    assign ctl_o = ctl_q;

    // R1
    ctl_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_i |=> (ctl_q == $past(ctl_q)));
endmodule

// File: rtl/evt_edge_bank.sv
module evt_edge_bank #(
    parameter int N = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] lvl_i,
    output logic [N-1:0] rise_o
);
    logic [N-1:0] prev_d, prev_q;

    always_comb begin
        prev_d = lvl_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= '0;
        else        prev_q <= prev_d;
    end

    for (genvar g = 0; g < N; g++) begin : g_bit
        assign rise_o[g] = lvl_i[g] & ~prev_q[g];

        // R3
        rise_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
            rise_o[g] |=> !rise_o[g]);
    end
endmodule

// File: rtl/adc1_skip_ctr.sv
module adc1_skip_ctr #(
    parameter int OFS_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic [OFS_W-1:0] load_val_i,
    input  logic [OFS_W-1:0] ofs_i,
    input  logic             evt_i,
    output logic             fire_o
);
    logic [OFS_W-1:0] cnt_d, cnt_q;
    logic             fire;

    always_comb begin
        cnt_d = cnt_q;
        fire  = 1'b0;
        if (load_i) begin
            cnt_d = load_val_i;
        end else if (evt_i) begin
            if (cnt_q == '0) begin
                fire  = 1'b1;
                cnt_d = ofs_i;
            end else begin
                cnt_d = cnt_q - 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign fire_o = fire;

    // R8
    cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= ofs_i);

    // R8
    reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fire_o |=> (cnt_q == ofs_i));

    // R9
    write_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load_i |=> (cnt_q == $past(load_val_i) && !$past(fire_o)));
endmodule

// File: rtl/pwm_evt_router.sv
module pwm_evt_router
    import pwm_evt_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        ctl_wr,
    input  logic [15:0] ctl_wdata,
    input  logic        eoc_pulse,
    input  logic        cmpa_pulse,
    input  logic        cmpb_pulse,
    input  logic        cmpc_pulse,
    input  logic        flt_lvl,
    input  logic        clim_lvl,
    input  logic        ffwd_lvl,
    input  logic        sync_lvl,
    output logic        irq_o,
    output logic        adc1_trig_o,
    output logic        adc2_trig_o
);
    typedef struct packed {
        logic irq;
        logic adc1;
        logic adc2;
    } out_t;

    evt_ctl_t          ctl;
    logic [STAT_N-1:0] st_lvl, st_rise, st_hit;
    logic [CMP_N-1:0]  cmp_evt;
    logic              a1_fire, tb_evt;
    out_t              out_d, out_q;

    assign st_lvl  = {flt_lvl, clim_lvl, ffwd_lvl, sync_lvl};
    assign cmp_evt = {cmpc_pulse, cmpb_pulse, cmpa_pulse};

    evt_ctl_reg u_ctl (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_i    (ctl_wr),
        .wdata_i (ctl_wdata),
        .ctl_o   (ctl)
    );

    evt_edge_bank #(.N(STAT_N)) u_edge (
        .clk    (clk),
        .rst_n  (rst_n),
        .lvl_i  (st_lvl),
        .rise_o (st_rise)
    );

    adc1_skip_ctr #(.OFS_W(OFS_W)) u_skip (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_i     (ctl_wr),
        .load_val_i (ctl_wdata[OFS_W-1:0]),
        .ofs_i      (ctl.ofs),
        .evt_i      (cmpa_pulse),
        .fire_o     (a1_fire)
    );

    always_comb begin
        unique case (ctl.tb_sel)
            TB_EOC:  tb_evt = eoc_pulse;
            TB_CMPA: tb_evt = cmpa_pulse;
            TB_ADC1: tb_evt = a1_fire;
            default: tb_evt = 1'b0;
        endcase
        st_hit     = st_rise & ctl.st_en;
        out_d.irq  = tb_evt | (|st_hit);
        out_d.adc1 = a1_fire;
        out_d.adc2 = |(cmp_evt & ctl.a2_en);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) out_q <= '0;
        else        out_q <= out_d;
    end

    assign irq_o       = out_q.irq;
    assign adc1_trig_o = out_q.adc1;
    assign adc2_trig_o = out_q.adc2;

    // R6
    tb_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl.tb_sel == TB_OFF && st_hit == '0) |=> !irq_o);

    // R7
    a2_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl.a2_en == '0) |=> !adc2_trig_o);

    // R2
    st_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl.st_en == '0 && !eoc_pulse && !cmpa_pulse && !a1_fire) |=> !irq_o);

    // R8
    adc1_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cmpa_pulse |=> !adc1_trig_o);
endmodule

// File: tb/pwm_evt_router_test.sv
module pwm_evt_router_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ctl_wr = 1'b0;
    logic [15:0] ctl_wdata = '0;
    logic [3:0]  ev = '0;   // {eoc, cmpA, cmpB, cmpC}
    logic [3:0]  st = '0;   // {fault, climit, ffwd, sync}
    logic        irq_o, adc1_trig_o, adc2_trig_o;
    int          errors = 0;
    int          checks = 0;

    always #2 clk = ~clk;   // 250 MHz

    pwm_evt_router uut (
        .clk         (clk),
        .rst_n       (rst_n),
        .ctl_wr      (ctl_wr),
        .ctl_wdata   (ctl_wdata),
        .eoc_pulse   (ev[3]),
        .cmpa_pulse  (ev[2]),
        .cmpb_pulse  (ev[1]),
        .cmpc_pulse  (ev[0]),
        .flt_lvl     (st[3]),
        .clim_lvl    (st[2]),
        .ffwd_lvl    (st[1]),
        .sync_lvl    (st[0]),
        .irq_o       (irq_o),
        .adc1_trig_o (adc1_trig_o),
        .adc2_trig_o (adc2_trig_o)
    );

    // {wr, wdata, ev, st, expected {irq, adc1, adc2}}
    localparam int NV = 20;
    localparam logic [27:0] VEC [NV] = '{
        {1'b0, 16'h0000, 4'b0000, 4'b0000, 3'b000}, // R1 idle
        {1'b0, 16'h0000, 4'b1000, 4'b0000, 3'b100}, // R5 eoc at sel 00
        {1'b0, 16'h0000, 4'b0100, 4'b0000, 3'b010}, // R8 N=0
        {1'b0, 16'h0000, 4'b0011, 4'b0000, 3'b000}, // R7 gates off
        {1'b0, 16'h0000, 4'b0000, 4'b1000, 3'b000}, // R2 enable off
        {1'b1, 16'hF1E2, 4'b0000, 4'b1000, 3'b000}, // write
        {1'b0, 16'h0000, 4'b0100, 4'b1000, 3'b101}, // R3 held, R5 sel 01
        {1'b0, 16'h0000, 4'b0100, 4'b1000, 3'b101}, // R8 skip
        {1'b0, 16'h0000, 4'b0100, 4'b0000, 3'b111}, // R8 fire, R3 fall
        {1'b0, 16'h0000, 4'b0000, 4'b0100, 3'b100}, // R2 climit
        {1'b0, 16'h0000, 4'b0000, 4'b0101, 3'b100}, // R2 sync
        {1'b0, 16'h0000, 4'b1000, 4'b0101, 3'b000}, // R5 eoc ignored
        {1'b0, 16'h0000, 4'b0011, 4'b0000, 3'b001}, // R7 merged
        {1'b1, 16'h0200, 4'b0100, 4'b0000, 3'b101}, // R9 write + cmpA
        {1'b0, 16'h0000, 4'b0100, 4'b0000, 3'b110}, // R5 sel 10
        {1'b0, 16'h0000, 4'b1000, 4'b0000, 3'b000}, // R5
        {1'b1, 16'h8300, 4'b0000, 4'b0000, 3'b000}, // write
        {1'b0, 16'h0000, 4'b1100, 4'b0000, 3'b010}, // R6 time base off
        {1'b0, 16'h0000, 4'b0000, 4'b1000, 3'b100}, // R6 status still
        {1'b0, 16'h0000, 4'b0000, 4'b0000, 3'b000}  // R10
    };

    task automatic chk(input string tag, input logic [2:0] got, input logic [2:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: {irq,adc1,adc2} got %b expected %b", tag, got, exp);
        end
    endtask

    task automatic step(input logic wr, input logic [15:0] wd,
                        input logic [3:0] e, input logic [3:0] s);
        ctl_wr = wr; ctl_wdata = wd; ev = e; st = s;
        @(negedge clk);
        ctl_wr = 1'b0; ev = '0;
    endtask

    function automatic logic [2:0] outs();
        return {irq_o, adc1_trig_o, adc2_trig_o};
    endfunction

    initial begin
        #(200000 * 4);
        errors++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        // R1: reset state, with events driven during reset
        step(1'b0, 16'h0000, 4'b1111, 4'b1111);
        chk("R1 in reset", outs(), 3'b000);
        step(1'b0, 16'h0000, 4'b0000, 4'b0000);
        rst_n = 1'b1;
        step(1'b0, 16'h0000, 4'b0000, 4'b0000);
        chk("R1 after reset", outs(), 3'b000);

        for (int i = 0; i < NV; i++) begin
            step(VEC[i][27], VEC[i][26:11], VEC[i][10:7], VEC[i][6:3]);
            chk($sformatf("R10 vector %0d", i), outs(), VEC[i][2:0]);
        end

        // R4: fault high through reset gives nothing until seen low
        rst_n = 1'b0;
        step(1'b0, 16'h0000, 4'b0000, 4'b1000);
        rst_n = 1'b1;
        step(1'b0, 16'h0000, 4'b0000, 4'b1000);
        step(1'b1, 16'h8000, 4'b0000, 4'b1000);
        for (int k = 0; k < 3; k++) begin
            step(1'b0, 16'h0000, 4'b0000, 4'b1000);
            chk("R4 held through reset", outs(), 3'b000);
        end
        step(1'b0, 16'h0000, 4'b0000, 4'b0000);
        chk("R4 fall", outs(), 3'b000);
        step(1'b0, 16'h0000, 4'b0000, 4'b1000);
        chk("R4 re-rise", outs(), 3'b100);

        // R8: skip 31 then fire, then reload
        step(1'b1, 16'h031F, 4'b0000, 4'b0000);
        for (int k = 0; k < 31; k++) begin
            step(1'b0, 16'h0000, 4'b0100, 4'b0000);
            chk("R8 skip 31", outs(), 3'b000);
        end
        step(1'b0, 16'h0000, 4'b0100, 4'b0000);
        chk("R8 fire after 31", outs(), 3'b010);
        step(1'b0, 16'h0000, 4'b0100, 4'b0000);
        chk("R8 reloaded", outs(), 3'b000);

        // R9: rewrite discards partial count
        step(1'b1, 16'h0303, 4'b0000, 4'b0000);
        step(1'b0, 16'h0000, 4'b0100, 4'b0000);
        step(1'b0, 16'h0000, 4'b0100, 4'b0000);
        step(1'b1, 16'h0303, 4'b0000, 4'b0000);
        for (int k = 0; k < 3; k++) begin
            step(1'b0, 16'h0000, 4'b0100, 4'b0000);
            chk("R9 partial dropped", outs(), 3'b000);
        end
        step(1'b0, 16'h0000, 4'b0100, 4'b0000);
        chk("R9 fire after reload", outs(), 3'b010);

        // R10: several interrupt sources in one cycle, one pulse
        step(1'b1, 16'hF000, 4'b0000, 4'b0000);
        step(1'b0, 16'h0000, 4'b1000, 4'b1111);
        chk("R10 merged irq", outs(), 3'b100);
        step(1'b0, 16'h0000, 4'b0000, 4'b0000);
        chk("R10 one cycle", outs(), 3'b000);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule